// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block turns the 6-bit major opcode of a 32-bit load/store instruction word, together with its 6-bit function field, into every control line that a one-instruction-per-clock datapath needs. It recognises five instruction classes: register-to-register arithmetic, word load, word store, branch-on-equal and unconditional jump. From the opcode it drives the steering controls: destination-register select, immediate operand select and write-back source. It also drives the enables that change state: register write, memory read, memory write, branch and jump. It produces a 2-bit operation class as well. A second stage combines that class with the function field and produces the 4-bit operation code that the arithmetic unit executes.

The whole path is combinational. Each instruction finishes in one clock period, so the controls must be valid in the same cycle that the opcode appears. There are no registers and no reset. Any opcode outside the five classes is treated as a bubble, and so is a register-class word with an unknown function field: neither one may write a register or memory, and neither may redirect the program counter.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: Opcode 000000 (register class) drives dst_sel_rd_o=1, alu_src_imm_o=0, wb_from_mem_o=0, mem_rd_en_o=0, mem_wr_en_o=0, branch_eq_o=0, jump_o=0 and alu_op_class_o=2'b10; reg_wr_en_o=1 when the function field is recognised.
- R2: Opcode 100011 (load) drives alu_src_imm_o=1, wb_from_mem_o=1, reg_wr_en_o=1, mem_rd_en_o=1, mem_wr_en_o=0, dst_sel_rd_o=0, branch_eq_o=0, jump_o=0 and alu_op_class_o=2'b00.
- R3: Opcode 101011 (store) drives alu_src_imm_o=1, mem_wr_en_o=1, mem_rd_en_o=0 and reg_wr_en_o=0, with all other flags 0 and alu_op_class_o=2'b00.
- R4: Opcode 000100 (branch-on-equal) drives branch_eq_o=1 and alu_op_class_o=2'b01, with reg_wr_en_o, mem_rd_en_o, mem_wr_en_o, jump_o and the steering flags all 0.
- R5: Opcode 000010 (jump) drives jump_o=1 and alu_op_class_o=2'b00, with every other flag 0.
- R6: Every other opcode drives all eight flags to 0 and alu_op_class_o=2'b00.
- R7: Load and store produce alu_code_o=4'b0010 (add), for address calculation.
- R8: Branch-on-equal produces alu_code_o=4'b0110 (subtract).
- R9: In the register class, the function field sets alu_code_o as follows: 100000 gives 0010 (add), 100010 gives 0110 (sub), 100100 gives 0000 (and), 100101 gives 0001 (or) and 101010 gives 0111 (set-less-than).
- R10: A register-class word with any other function field forces reg_wr_en_o=0 and alu_code_o=4'b0010, while the other outputs keep their R1 values.
- R11: For every opcode other than 000000, the function field has no effect on any output.
- R12: Every output follows its inputs in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Major opcode of the current instruction |
| funct_i | input | 6 | Function field of the current instruction |
| dst_sel_rd_o | output | 1 | Destination register taken from the third register field |
| alu_src_imm_o | output | 1 | Second operand is the sign-extended immediate |
| wb_from_mem_o | output | 1 | Write-back value comes from data memory |
| reg_wr_en_o | output | 1 | Register file write enable |
| mem_rd_en_o | output | 1 | Data memory read enable |
| mem_wr_en_o | output | 1 | Data memory write enable |
| branch_eq_o | output | 1 | Branch taken when the operands are equal |
| jump_o | output | 1 | Unconditional jump |
| alu_op_class_o | output | 2 | Operation class sent to the operation decoder |
| alu_code_o | output | 4 | Operation code for the arithmetic unit |

## Verification
The bench sweeps all 64 opcodes. A decoder that matched only a few bits of the opcode would let a neighbouring unused opcode assert a write or a branch. It also sweeps all 64 function codes under the register class. A design that failed to gate the write enable would commit a result computed with a default operation. Pairs of vectors that differ only in the function field of a load, a branch or an unused opcode catch a design whose function decode leaks outside the register class. The store and branch vectors catch a design that leaves memory read or register write enabled.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;

  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int CODE_W  = 4;
  localparam int CLASS_W = 2;

  // opcode values the decoder recognises
  localparam logic [OPC_W-1:0] OPC_RREG  = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  // function field values of the register class
  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  // operation class handed to the second stage
  localparam logic [CLASS_W-1:0] CLS_MEMADDR = 2'b00;
  localparam logic [CLASS_W-1:0] CLS_COMPARE = 2'b01;
  localparam logic [CLASS_W-1:0] CLS_FUNCT   = 2'b10;

  // arithmetic unit operation codes
  localparam logic [CODE_W-1:0] OP_AND = 4'b0000;
  localparam logic [CODE_W-1:0] OP_OR  = 4'b0001;
  localparam logic [CODE_W-1:0] OP_ADD = 4'b0010;
  localparam logic [CODE_W-1:0] OP_SUB = 4'b0110;
  localparam logic [CODE_W-1:0] OP_SLT = 4'b0111;

  // one-hot index of each instruction class
  typedef enum logic [2:0] {
    IC_RREG  = 3'd0,
    IC_LOAD  = 3'd1,
    IC_STORE = 3'd2,
    IC_BEQ   = 3'd3,
    IC_JUMP  = 3'd4
  } iclass_e;

  localparam int IC_N = 5;

  typedef struct packed {
    logic                dst_rd;
    logic                src_imm;
    logic                wb_mem;
    logic                reg_wr;
    logic                mem_rd;
    logic                mem_wr;
    logic                branch;
    logic                jump;
    logic [CLASS_W-1:0]  op_class;
  } ctl_t;

endpackage

// File: rtl/sc_opc_class.sv
module sc_opc_class
  import sc_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output logic [IC_N-1:0]  class_oh_o
);

  localparam logic [OPC_W-1:0] OPC_TAB [IC_N] =
    '{OPC_RREG, OPC_LOAD, OPC_STORE, OPC_BEQ, OPC_JUMP};

  for (genvar gi = 0; gi < IC_N; gi++) begin : g_match
    assign class_oh_o[gi] = (opcode_i == OPC_TAB[gi]);
  end

endmodule

// File: rtl/sc_main_ctl.sv
module sc_main_ctl
  import sc_ctrl_pkg::*;
(
  input  logic [IC_N-1:0] class_oh_i,
  output ctl_t            ctl_o
);

  always_comb begin
    ctl_o = '0;
    ctl_o.op_class = CLS_MEMADDR;
    unique case (1'b1)
      class_oh_i[IC_RREG]: begin
        ctl_o.dst_rd   = 1'b1;
        ctl_o.reg_wr   = 1'b1;
        ctl_o.op_class = CLS_FUNCT;
      end
      class_oh_i[IC_LOAD]: begin
        ctl_o.src_imm = 1'b1;
        ctl_o.wb_mem  = 1'b1;
        ctl_o.reg_wr  = 1'b1;
        ctl_o.mem_rd  = 1'b1;
      end
      class_oh_i[IC_STORE]: begin
        ctl_o.src_imm = 1'b1;
        ctl_o.mem_wr  = 1'b1;
      end
      class_oh_i[IC_BEQ]: begin
        ctl_o.branch   = 1'b1;
        ctl_o.op_class = CLS_COMPARE;
      end
      class_oh_i[IC_JUMP]: begin
        ctl_o.jump = 1'b1;
      end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/sc_alu_ctl.sv
module sc_alu_ctl
  import sc_ctrl_pkg::*;
(
  input  logic [CLASS_W-1:0] op_class_i,
  input  logic [FN_W-1:0]    funct_i,
  output logic [CODE_W-1:0]  code_o,
  output logic               funct_ok_o
);

  logic [CODE_W-1:0] fn_code;
  logic              fn_hit;

  always_comb begin
    fn_hit  = 1'b1;
    fn_code = OP_ADD;
    case (funct_i)
      FN_ADD:  fn_code = OP_ADD;
      FN_SUB:  fn_code = OP_SUB;
      FN_AND:  fn_code = OP_AND;
      FN_OR:   fn_code = OP_OR;
      FN_SLT:  fn_code = OP_SLT;
      default: fn_hit  = 1'b0;
    endcase
  end

  always_comb begin
    funct_ok_o = 1'b0;
    case (op_class_i)
      CLS_COMPARE: code_o = OP_SUB;
      CLS_FUNCT: begin
        code_o     = fn_code;
        funct_ok_o = fn_hit;
      end
      default:     code_o = OP_ADD;
    endcase
  end

endmodule

// File: rtl/sc_ctrl_decoder.sv
module sc_ctrl_decoder
  import sc_ctrl_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output logic       dst_sel_rd_o,
  output logic       alu_src_imm_o,
  output logic       wb_from_mem_o,
  output logic       reg_wr_en_o,
  output logic       mem_rd_en_o,
  output logic       mem_wr_en_o,
  output logic       branch_eq_o,
  output logic       jump_o,
  output logic [1:0] alu_op_class_o,
  output logic [3:0] alu_code_o
);

  logic [IC_N-1:0]   class_oh;
  ctl_t              ctl;
  logic              funct_ok;
  logic [CODE_W-1:0] code;

  sc_opc_class u_class (
    .opcode_i   (opcode_i),
    .class_oh_o (class_oh)
  );

  sc_main_ctl u_main (
    .class_oh_i (class_oh),
    .ctl_o      (ctl)
  );

  sc_alu_ctl u_alu (
    .op_class_i (ctl.op_class),
    .funct_i    (funct_i),
    .code_o     (code),
    .funct_ok_o (funct_ok)
  );

  // R10: an unrecognised function field in the register class is a bubble
  logic rreg_bad;
  assign rreg_bad = (ctl.op_class == CLS_FUNCT) && !funct_ok;

  assign dst_sel_rd_o   = ctl.dst_rd;
  assign alu_src_imm_o  = ctl.src_imm;
  assign wb_from_mem_o  = ctl.wb_mem;
  assign reg_wr_en_o    = ctl.reg_wr && !rreg_bad;
  assign mem_rd_en_o    = ctl.mem_rd;
  assign mem_wr_en_o    = ctl.mem_wr;
  assign branch_eq_o    = ctl.branch;
  assign jump_o         = ctl.jump;
  assign alu_op_class_o = ctl.op_class;
  assign alu_code_o     = code;

  // cross-module consistency checks between the main and operation stages
  always_comb begin
    a_r2_r3_mem_excl: assert (!(mem_rd_en_o && mem_wr_en_o))
      else $error("memory read and write both enabled");
    a_r7_mem_add: assert (!(mem_rd_en_o || mem_wr_en_o) || alu_code_o == OP_ADD)
      else $error("memory access without add code");
    a_r8_branch_sub: assert (!branch_eq_o || alu_code_o == OP_SUB)
      else $error("branch without subtract code");
    a_r5_jump_quiet: assert (!jump_o || !(reg_wr_en_o || mem_wr_en_o || mem_rd_en_o))
      else $error("jump with a state-changing enable");
    a_r6_onehot_action: assert ($onehot0({mem_rd_en_o, mem_wr_en_o, branch_eq_o, jump_o}))
      else $error("more than one action enable");
    a_r10_funct_gate: assert (!(reg_wr_en_o && alu_op_class_o == CLS_FUNCT) || funct_ok)
      else $error("register write with unknown function field");
    a_r2_wb_needs_read: assert (!wb_from_mem_o || mem_rd_en_o)
      else $error("memory write-back without memory read");
  end

endmodule

// File: tb/sc_ctrl_decoder_tb_top.sv
module sc_ctrl_decoder_tb_top;

  logic clk;
  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [5:0] opcode, funct;
  logic dst, src, wbm, rw, mr, mw, br, jp;
  logic [1:0] cls;
  logic [3:0] code;

  sc_ctrl_decoder dut_i (
    .opcode_i (opcode), .funct_i (funct),
    .dst_sel_rd_o (dst), .alu_src_imm_o (src), .wb_from_mem_o (wbm),
    .reg_wr_en_o (rw), .mem_rd_en_o (mr), .mem_wr_en_o (mw),
    .branch_eq_o (br), .jump_o (jp),
    .alu_op_class_o (cls), .alu_code_o (code)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // {opcode, funct, dst src wbm rw mr mw br jp, class, code}
  localparam int NV = 15;
  localparam logic [25:0] VEC [NV] = '{
    {6'b000000, 6'b100000, 8'b1001_0000, 2'b10, 4'b0010},
    {6'b000000, 6'b100010, 8'b1001_0000, 2'b10, 4'b0110},
    {6'b000000, 6'b100100, 8'b1001_0000, 2'b10, 4'b0000},
    {6'b000000, 6'b100101, 8'b1001_0000, 2'b10, 4'b0001},
    {6'b000000, 6'b101010, 8'b1001_0000, 2'b10, 4'b0111},
    {6'b000000, 6'b111111, 8'b1000_0000, 2'b10, 4'b0010},
    {6'b100011, 6'b000000, 8'b0111_1000, 2'b00, 4'b0010},
    {6'b100011, 6'b101010, 8'b0111_1000, 2'b00, 4'b0010},
    {6'b101011, 6'b100010, 8'b0100_0100, 2'b00, 4'b0010},
    {6'b000100, 6'b000000, 8'b0000_0010, 2'b01, 4'b0110},
    {6'b000100, 6'b100101, 8'b0000_0010, 2'b01, 4'b0110},
    {6'b000010, 6'b100100, 8'b0000_0001, 2'b00, 4'b0010},
    {6'b111111, 6'b100000, 8'b0000_0000, 2'b00, 4'b0010},
    {6'b001000, 6'b100000, 8'b0000_0000, 2'b00, 4'b0010},
    {6'b100001, 6'b101010, 8'b0000_0000, 2'b00, 4'b0010}
  };

  function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'b000000: return (fn inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h2A}) ? "R1/R9" : "R10";
      6'b100011: return "R2/R7/R11";
      6'b101011: return "R3/R7";
      6'b000100: return "R4/R8/R11";
      6'b000010: return "R5";
      default:   return "R6/R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b", req, opcode, funct, act, exp);
    end
  endtask

  function automatic logic [13:0] outs();
    return {dst, src, wbm, rw, mr, mw, br, jp, cls, code};
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn);
    @(posedge clk);
    opcode = op;
    funct  = fn;
    @(negedge clk);
  endtask

  initial begin
    opcode = '0;
    funct  = '0;
    // R12: values are checked in the same cycle the inputs change
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][25:20], VEC[i][19:14]);
      check(tag_of(VEC[i][25:20], VEC[i][19:14]), outs(), VEC[i][13:0]);
    end

    // R6: opcode sweep, unused opcodes must leave every enable low
    for (int op = 0; op < 64; op++) begin
      logic [5:0] o6;
      o6 = 6'(op);
      if (!(o6 inside {6'b000000, 6'b100011, 6'b101011, 6'b000100, 6'b000010})) begin
        apply(o6, 6'b100000);
        check("R6", outs(), {8'b0, 2'b00, 4'b0010});
      end
    end

    // R9/R10: function sweep in the register class
    for (int fn = 0; fn < 64; fn++) begin
      logic [5:0] f6;
      logic [3:0] ec;
      logic       ok;
      f6 = 6'(fn);
      ok = 1'b1;
      case (f6)
        6'h20:   ec = 4'b0010;
        6'h22:   ec = 4'b0110;
        6'h24:   ec = 4'b0000;
        6'h25:   ec = 4'b0001;
        6'h2A:   ec = 4'b0111;
        default: begin ec = 4'b0010; ok = 1'b0; end
      endcase
      apply(6'b000000, f6);
      check(ok ? "R9" : "R10", outs(), {1'b1, 2'b00, ok, 4'b0000, 2'b10, ec});
    end

    // R11: function field swept under store and jump changes nothing
    for (int fn = 0; fn < 64; fn += 9) begin
      apply(6'b101011, 6'(fn));
      check("R11", outs(), {8'b0100_0100, 2'b00, 4'b0010});
      apply(6'b000010, 6'(fn));
      check("R11", outs(), {8'b0000_0001, 2'b00, 4'b0010});
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule